// File: doc/BRIEF.md
# Block-transfer micro-op sequencer

This block sits behind an instruction decoder and breaks one multi-register load or store into a stream of single-register micro-operations, one per cycle. The decoder hands over a register mask, the base register number and five mode flags (pre-index, ascending, user bank, base update, load). The block then emits a base-copy micro-op and one transfer micro-op per set bit of the mask. If base update is requested, it closes with one micro-op that moves the base register past the transferred block.

Each micro-op carries an opcode, a register index, an offset (or an immediate for the base-update step) and a flag marking the final micro-op of the instruction. The first micro-op copies the base into a scratch register by adding zero to it. Every transfer offset is relative to that scratch copy, so the base-update step cannot disturb the addresses. The starting offset comes from the ascending and pre-index flags. The register mask is consumed from its lowest set bit upward. The output follows a valid/ready handshake, and a new instruction is taken only when the block is idle.

Top module: `ldm_uop_seq`

## Requirements
- R1: `in_ready` is high exactly when no instruction is in progress. In the cycle after an accepted instruction, the block presents a micro-op with opcode 0 (base copy), register = base register number and offset 0. Input offered while busy is ignored.
- R2: An instruction produces (number of set mask bits) + 1 micro-ops, plus one more when base update is requested.
- R3: The first transfer offset is 0 when ascending and 4·n−4 when descending, where n is the set-bit count. Pre-index adds 4 to that value. All offsets are modulo 2^OFS_W.
- R4: Transfers name the set mask bits in increasing bit order, one micro-op each. The register index is the bit number.
- R5: Each later transfer offset is the previous one plus 4 when ascending, or minus 4 when descending.
- R6: With the user-bank flag set, each transfer register index is the bit number plus TOTAL_REGS (default 32).
- R7: With base update, the final micro-op has opcode 3 (base add) when ascending or opcode 4 (base subtract) when descending. Its register is the base register number and its offset is 4·n.
- R8: Only the final micro-op of an instruction carries `uop_last`. After that micro-op is taken, `uop_valid` falls.
- R9: Transfers use opcode 1 (load) when the load flag is set and opcode 2 (store) when it is clear.
- R10: While `uop_valid` is high and `uop_ready` is low, all micro-op outputs hold their values.
- R11: An empty mask yields only the base copy, followed by the base-update micro-op when that is requested. The last flag sits on whichever of these is emitted last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken this cycle if offered |
| in_mask | input | NREG | Register mask |
| in_pre | input | 1 | Pre-index: offsets start one word further |
| in_up | input | 1 | Ascending addresses |
| in_user | input | 1 | Steer transfers to the user register bank |
| in_wb | input | 1 | Append base-update micro-op |
| in_load | input | 1 | Load (1) or store (0) |
| in_base | input | clog2(NREG) | Base register number |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes micro-op |
| uop_op | output | 3 | Opcode: 0 copy, 1 load, 2 store, 3 base add, 4 base subtract |
| uop_reg | output | clog2(TOTAL_REGS+NREG) | Register index |
| uop_ofs | output | OFS_W | Offset from base copy, or base-update immediate |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The bench targets the offset arithmetic at its edges. These are the full sixteen-register descending list, where a wrong start would put the first word 4 bytes off or wrap the offset, and the single top-register list with pre-index, where an off-by-one in the pre adjustment shows up directly. Empty masks, with and without base update, catch a design that emits a stray transfer or puts the last flag on the base copy when base update is pending. Stalled consumers and instructions offered mid-stream would expose a design that advances on a dropped handshake or accepts a second instruction and corrupts the mask. User-bank cases would show an unshifted register index.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;
   typedef enum logic [2:0] {
      UOP_COPY  = 3'd0,
      UOP_LOAD  = 3'd1,
      UOP_STORE = 3'd2,
      UOP_BADD  = 3'd3,
      UOP_BSUB  = 3'd4
   } uop_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_COPY,
      ST_XFER,
      ST_WB
   } seq_st_e;
endpackage

// File: rtl/ldm_popcount.sv
module ldm_popcount #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] part [0:N];

   assign part[0] = '0;
   for (genvar i = 0; i < N; i++) begin : g_sum
      assign part[i+1] = part[i] + CW'(vec[i]);
   end
   assign cnt = part[N];
endmodule

// File: rtl/ldm_lowbit.sv
module ldm_lowbit #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  rest
);
   logic [IW-1:0] pick [0:N];

   // scan from the top so the lowest set bit wins
   assign pick[N] = '0;
   for (genvar i = N - 1; i >= 0; i--) begin : g_scan
      assign pick[i] = vec[i] ? IW'(i) : pick[i+1];
   end
   assign idx  = pick[0];
   assign rest = vec & (vec - N'(1));
endmodule

// File: rtl/ldm_start_ofs.sv
module ldm_start_ofs #(
   parameter int CW    = 5,
   parameter int OFS_W = 8
) (
   input  logic [CW-1:0]    cnt,
   input  logic             up,
   input  logic             pre,
   output logic [OFS_W-1:0] ofs
);
   localparam logic [OFS_W-1:0] WORD = OFS_W'(4);
   logic [OFS_W-1:0] span;
   logic [OFS_W-1:0] dir_ofs;

   assign span    = OFS_W'(cnt) << 2;
   assign dir_ofs = up ? '0 : span - WORD;
   assign ofs     = pre ? dir_ofs + WORD : dir_ofs;
endmodule

// File: rtl/ldm_uop_seq.sv
module ldm_uop_seq
   import ldm_seq_pkg::*;
#(
   parameter int NREG       = 16,
   parameter int TOTAL_REGS = 32,
   parameter int OFS_W      = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   output logic                                 in_ready,
   input  logic [NREG-1:0]                      in_mask,
   input  logic                                 in_pre,
   input  logic                                 in_up,
   input  logic                                 in_user,
   input  logic                                 in_wb,
   input  logic                                 in_load,
   input  logic [$clog2(NREG)-1:0]              in_base,
   output logic                                 uop_valid,
   input  logic                                 uop_ready,
   output logic [2:0]                           uop_op,
   output logic [$clog2(TOTAL_REGS+NREG)-1:0]   uop_reg,
   output logic [OFS_W-1:0]                     uop_ofs,
   output logic                                 uop_last
);
   localparam int BW = $clog2(NREG);
   localparam int RW = $clog2(TOTAL_REGS + NREG);
   localparam int CW = $clog2(NREG + 1);
   localparam logic [OFS_W-1:0] WORD = OFS_W'(4);

   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end
   if (TOTAL_REGS < NREG) begin : g_bad_total
      $error("TOTAL_REGS must cover the architectural registers");
   end
   if (OFS_W < $clog2(4 * NREG + 1)) begin : g_bad_ofs
      $error("OFS_W too narrow for the largest block");
   end

   seq_st_e          st_q;
   logic [NREG-1:0]  rem_q;
   logic             up_q, user_q, wb_q, load_q;
   logic [BW-1:0]    base_q;
   logic [CW-1:0]    cnt_q;
   logic [OFS_W-1:0] ofs_q;

   logic [CW-1:0]    in_cnt;
   logic [OFS_W-1:0] in_ofs;
   logic [BW-1:0]    low_idx;
   logic [NREG-1:0]  rem_clr;
   logic             accept, fire;

   ldm_popcount #(.N(NREG), .CW(CW)) i_cnt (
      .vec (in_mask),
      .cnt (in_cnt)
   );

   ldm_start_ofs #(.CW(CW), .OFS_W(OFS_W)) i_start (
      .cnt (in_cnt),
      .up  (in_up),
      .pre (in_pre),
      .ofs (in_ofs)
   );

   ldm_lowbit #(.N(NREG), .IW(BW)) i_low (
      .vec  (rem_q),
      .idx  (low_idx),
      .rest (rem_clr)
   );

   assign in_ready  = (st_q == ST_IDLE);
   assign uop_valid = (st_q != ST_IDLE);
   assign accept    = in_valid && in_ready;
   assign fire      = uop_valid && uop_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         up_q   <= 1'b0;
         user_q <= 1'b0;
         wb_q   <= 1'b0;
         load_q <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
         ofs_q  <= '0;
      end else if (accept) begin
         st_q   <= ST_COPY;
         rem_q  <= in_mask;
         up_q   <= in_up;
         user_q <= in_user;
         wb_q   <= in_wb;
         load_q <= in_load;
         base_q <= in_base;
         cnt_q  <= in_cnt;
         ofs_q  <= in_ofs;
      end else if (fire) begin
         unique case (st_q)
            ST_COPY: begin
               if (rem_q != '0)  st_q <= ST_XFER;
               else if (wb_q)    st_q <= ST_WB;
               else              st_q <= ST_IDLE;
            end
            ST_XFER: begin
               rem_q <= rem_clr;
               ofs_q <= up_q ? ofs_q + WORD : ofs_q - WORD;
               if (rem_clr != '0) st_q <= ST_XFER;
               else if (wb_q)     st_q <= ST_WB;
               else               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      uop_op   = UOP_COPY;
      uop_reg  = RW'(base_q);
      uop_ofs  = '0;
      uop_last = 1'b0;
      unique case (st_q)
         ST_COPY: begin
            uop_last = (rem_q == '0) && !wb_q;
         end
         ST_XFER: begin
            uop_op   = load_q ? UOP_LOAD : UOP_STORE;
            uop_reg  = user_q ? RW'(low_idx) + RW'(TOTAL_REGS) : RW'(low_idx);
            uop_ofs  = ofs_q;
            uop_last = (rem_clr == '0) && !wb_q;
         end
         ST_WB: begin
            uop_op   = up_q ? UOP_BADD : UOP_BSUB;
            uop_ofs  = OFS_W'(cnt_q) << 2;
            uop_last = 1'b1;
         end
         default: begin
            uop_last = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/ldm_uop_seq_chk.sv
module ldm_uop_seq_chk #(
   parameter int NREG       = 16,
   parameter int TOTAL_REGS = 32,
   parameter int OFS_W      = 8
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               in_valid,
   input logic                               in_ready,
   input logic                               in_up,
   input logic                               in_user,
   input logic                               uop_valid,
   input logic                               uop_ready,
   input logic [2:0]                         uop_op,
   input logic [$clog2(TOTAL_REGS+NREG)-1:0] uop_reg,
   input logic [OFS_W-1:0]                   uop_ofs,
   input logic                               uop_last
);
   logic up_l, user_l;
   logic is_x;
   assign is_x = (uop_op == 3'd1) || (uop_op == 3'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_l   <= 1'b0;
         user_l <= 1'b0;
      end else if (in_valid && in_ready) begin
         up_l   <= in_up;
         user_l <= in_user;
      end
   end

   // R1
   idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !uop_valid);

   // R1
   first_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (uop_valid && uop_op == 3'd0 && uop_ofs == '0));

   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_ready && is_x && !uop_last) |=>
         (!(uop_valid && is_x) ||
          uop_ofs == (up_l ? $past(uop_ofs) + OFS_W'(4) : $past(uop_ofs) - OFS_W'(4))));

   // R6
   user_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && is_x && user_l) |-> (uop_reg >= TOTAL_REGS));

   // R7
   wb_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_op >= 3'd3) |-> uop_last);

   // R8
   end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_ready && uop_last) |=> !uop_valid);

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && !uop_ready) |=>
         (uop_valid && $stable(uop_op) && $stable(uop_reg) &&
          $stable(uop_ofs) && $stable(uop_last)));
endmodule

bind ldm_uop_seq ldm_uop_seq_chk #(
   .NREG(NREG), .TOTAL_REGS(TOTAL_REGS), .OFS_W(OFS_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_up     (in_up),
   .in_user   (in_user),
   .uop_valid (uop_valid),
   .uop_ready (uop_ready),
   .uop_op    (uop_op),
   .uop_reg   (uop_reg),
   .uop_ofs   (uop_ofs),
   .uop_last  (uop_last)
);

// File: tb/test_ldm_uop_seq.sv
module test_ldm_uop_seq;
   localparam int NREG = 16;
   localparam int TOT  = 32;
   localparam int OW   = 8;
   localparam int NV   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [15:0] in_mask = '0;
   logic       in_pre = 0, in_up = 0, in_user = 0, in_wb = 0, in_load = 0;
   logic [3:0] in_base = '0;
   logic       uop_valid;
   logic       uop_ready = 1'b0;
   logic [2:0] uop_op;
   logic [5:0] uop_reg;
   logic [7:0] uop_ofs;
   logic       uop_last;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   ldm_uop_seq #(.NREG(NREG), .TOTAL_REGS(TOT), .OFS_W(OW)) i_ldm_uop_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_mask(in_mask), .in_pre(in_pre), .in_up(in_up), .in_user(in_user),
      .in_wb(in_wb), .in_load(in_load), .in_base(in_base),
      .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
      .uop_reg(uop_reg), .uop_ofs(uop_ofs), .uop_last(uop_last)
   );

   // {mask, pre, up, user, wb, load, base, stall, junk, expected count}
   localparam logic [31:0] VEC [0:NV-1] = '{
      {16'h00F1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd13, 1'b0, 1'b0, 5'd7},
      {16'h8001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2,  1'b0, 1'b0, 5'd4},
      {16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 1'b0, 5'd17},
      {16'h0420, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7,  1'b0, 1'b1, 5'd3},
      {16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9,  1'b0, 1'b0, 5'd2},
      {16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0, 1'b1, 5'd1},
      {16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3,  1'b1, 1'b0, 5'd2},
      {16'h5555, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1,  1'b1, 1'b1, 5'd10}
   };

   int e_n;
   int e_op   [0:17];
   int e_reg  [0:17];
   int e_ofs  [0:17];
   int e_last [0:17];

   task automatic chk(input string rq, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic model(input logic [15:0] m, input logic pre, up, user, wb, load,
                        input logic [3:0] base);
      int n;
      int ofs;
      n = 0;
      for (int i = 0; i < 16; i++) if (m[i]) n++;
      ofs = up ? 0 : 4 * n - 4;
      if (pre) ofs = ofs + 4;
      e_n = 0;
      e_op[0] = 0; e_reg[0] = base; e_ofs[0] = 0; e_last[0] = 0;
      e_n = 1;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            e_op[e_n]   = load ? 1 : 2;
            e_reg[e_n]  = user ? i + TOT : i;
            e_ofs[e_n]  = ofs & 255;
            e_last[e_n] = 0;
            ofs = up ? ofs + 4 : ofs - 4;
            e_n++;
         end
      end
      if (wb) begin
         e_op[e_n] = up ? 3 : 4; e_reg[e_n] = base;
         e_ofs[e_n] = (4 * n) & 255; e_last[e_n] = 0;
         e_n++;
      end
      e_last[e_n-1] = 1;
   endtask

   task automatic run_vec(input logic [31:0] v);
      logic stall, junk, rdy;
      int k, guard, expn, first_x;
      logic [2:0] h_op; logic [5:0] h_reg; logic [7:0] h_ofs; logic h_last;
      stall = v[6]; junk = v[5]; expn = int'(v[4:0]);
      model(v[31:16], v[15], v[14], v[13], v[12], v[11], v[10:7]);
      @(negedge clk);
      chk("R1", in_ready, 1, "idle ready");
      in_mask = v[31:16]; in_pre = v[15]; in_up = v[14]; in_user = v[13];
      in_wb = v[12]; in_load = v[11]; in_base = v[10:7]; in_valid = 1'b1;
      uop_ready = 1'b0;
      @(negedge clk);
      if (junk) begin
         in_mask = 16'hA5A5; in_base = 4'd11; in_up = ~in_up;
      end else in_valid = 1'b0;
      k = 0; guard = 0; rdy = 1'b0; first_x = 1;
      h_op = '0; h_reg = '0; h_ofs = '0; h_last = 1'b0;
      while (k < e_n && guard < 100) begin
         guard++;
         chk("R1", in_ready, 0, "busy not ready");
         chk("R2", uop_valid, 1, "valid in stream");
         if (rdy == 1'b0 && guard > 1) begin
            chk("R10", {uop_op, uop_reg, uop_ofs, uop_last},
                {h_op, h_reg, h_ofs, h_last}, "held output");
         end
         chk(k == 0 ? "R1" : (e_op[k] >= 3 ? "R7" : "R9"), uop_op, e_op[k], "opcode");
         chk(k == 0 ? "R1" : (e_op[k] >= 3 ? "R7" : (v[13] ? "R6" : "R4")),
             uop_reg, e_reg[k], "register");
         chk(k == 0 ? "R1" : (e_op[k] >= 3 ? "R7" : (first_x ? "R3" : "R5")),
             uop_ofs, e_ofs[k], "offset");
         chk(v[31:16] == 0 ? "R11" : "R8", uop_last, e_last[k], "last flag");
         h_op = uop_op; h_reg = uop_reg; h_ofs = uop_ofs; h_last = uop_last;
         rdy = stall ? guard[0] : 1'b1;
         uop_ready = rdy;
         @(negedge clk);
         if (rdy) begin
            if (e_op[k] == 1 || e_op[k] == 2) first_x = 0;
            k++;
         end
      end
      in_valid = 1'b0;
      uop_ready = 1'b0;
      chk(v[31:16] == 0 ? "R11" : "R2", k, expn, "micro-op count");
      chk("R8", uop_valid, 0, "valid after last");
      chk("R1", in_ready, 1, "ready after last");
   endtask

   initial begin
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", uop_valid, 0, "reset valid");
      chk("R1", in_ready, 1, "reset ready");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", uop_valid, 0, "post-reset valid");
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);
      // R10: stall the base-copy micro-op for several cycles, then drain
      model(16'h0003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4);
      in_mask = 16'h0003; in_pre = 0; in_up = 1; in_user = 0; in_wb = 0;
      in_load = 1; in_base = 4'd4; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10", uop_op, 0, "long stall opcode");
      chk("R10", uop_reg, 4, "long stall register");
      uop_ready = 1'b1;
      @(negedge clk);
      chk("R4", uop_reg, 0, "first transfer after stall");
      @(negedge clk);
      chk("R4", uop_reg, 1, "second transfer after stall");
      chk("R5", uop_ofs, 4, "second offset after stall");
      chk("R8", uop_last, 1, "last after stall");
      @(negedge clk);
      chk("R8", uop_valid, 0, "drained");
      uop_ready = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule